// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block takes a 32-bit physical address and works out which DRAM chip-select row holds it. The rows are described by eight 8-bit boundary registers. Each register holds the running total of memory up to and including its row, in 8 MB steps. Software or a boot sequencer loads the registers through a simple write port. After that, the memory controller presents one address per lookup and gets back the row index together with a flag that says whether the address hits any populated row.

Row 0 starts at address zero, and each later row starts where the row before it ends. A register equal to its predecessor describes an empty row, which is never selected. A zero written after a nonzero running total means the limit has reached 2 GB, one step beyond what the 8-bit field can count. The lookup is combinational and is registered once, so each result appears on the clock edge after its request.

Top module: `row_bound_decoder`

## Requirements
- R1: After reset, all eight boundary registers read as 0, so every row is empty and every lookup returns hit_in_range = 0 and hit_row = 0.
- R2: When cfg_we is high on a clock edge, cfg_value is stored in the boundary register selected by cfg_row, where index 0 is row 0. A lookup issued on any later edge sees the new value.
- R3: The exclusive upper limit of row i is its register value times 2^23 bytes. Its inclusive base is the limit of row i-1, and row 0 has a base of 0. An address is inside a row when base <= address < limit.
- R4: A row whose limit equals its base is empty. No address ever selects it.
- R5: A register value of 0 whose preceding limit is nonzero is taken as a limit of 2^31 (2 GB). A row that follows a 2 GB limit and also holds 0 is empty.
- R6: When more than one row contains the address, which can happen when the boundaries are not monotonic, the lowest-numbered such row is reported.
- R7: When no row contains the address, hit_in_range is 0 and hit_row is 0.
- R8: hit_valid is high exactly on the cycle after an edge that sampled look_valid high. hit_in_range and hit_row then describe that lookup, and they hold their values while no lookup is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Boundary register write strobe |
| cfg_row | input | 3 | Index of the register to write |
| cfg_value | input | 8 | Cumulative boundary in 8 MB units |
| look_valid | input | 1 | Lookup request |
| look_addr | input | 32 | Physical address to decode |
| hit_valid | output | 1 | Result strobe, one cycle after a request |
| hit_in_range | output | 1 | Address lies in a populated row |
| hit_row | output | 3 | Selected row index, 0 on a miss |

## Verification
The bench probes the last byte and the first byte of each row boundary, because an off-by-one comparison would give the wrong row or a false miss exactly there. It builds a layout with a repeated boundary to show that an empty row is skipped rather than chosen, and it puts the top row at 2 GB to show that the zero-means-2 GB rule is applied. A decoder without that rule would report addresses just below 2 GB as misses. A non-monotonic layout creates overlapping ranges, which exposes a priority encoder that picks the highest match or several matches at once. A fresh reset followed by lookups confirms that an unprogrammed decoder reports nothing in range.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  parameter int BND_W     = 8;
  parameter int UNIT_SHFT = 23;
  localparam int LIM_W    = BND_W + UNIT_SHFT + 1;

  typedef logic [BND_W-1:0] bnd_t;
  typedef logic [LIM_W-1:0] lim_t;

  localparam lim_t TOP_LIMIT = lim_t'(1) << (BND_W + UNIT_SHFT);

  // Turn a raw boundary into a byte limit. A zero that follows a nonzero limit wraps to the top.
  function automatic lim_t calc_limit(input bnd_t raw, input lim_t prev);
    lim_t scaled;
    scaled = lim_t'(raw) << UNIT_SHFT;
    if (raw == '0 && prev != '0) return TOP_LIMIT;
    return scaled;
  endfunction
endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile
  import rbd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  localparam int IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  bnd_t             wdata,
  output bnd_t             bnd [NUM_ROWS]
);
  bnd_t store_q [NUM_ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ROWS; i++) store_q[i] <= '0;
    end else if (we) begin
      store_q[idx] <= wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ROWS; i++) bnd[i] = store_q[i];
  end
endmodule

// File: rtl/rbd_limit_chain.sv
module rbd_limit_chain
  import rbd_pkg::*;
#(
  parameter int NUM_ROWS = 8
) (
  input  bnd_t bnd [NUM_ROWS],
  output lim_t lim [NUM_ROWS],
  output lim_t base [NUM_ROWS]
);
  genvar g;
  generate
    for (g = 0; g < NUM_ROWS; g++) begin : g_row
      if (g == 0) begin : g_first
        assign base[g] = '0;
      end else begin : g_next
        assign base[g] = lim[g-1];
      end
      assign lim[g] = calc_limit(bnd[g], base[g]);
    end
  endgenerate
endmodule

// File: rtl/rbd_match.sv
module rbd_match
  import rbd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = $clog2(NUM_ROWS),
  localparam int CMP_W   = (LIM_W > ADDR_W) ? LIM_W : ADDR_W
) (
  input  logic [ADDR_W-1:0]   addr,
  input  lim_t                lim [NUM_ROWS],
  input  lim_t                base [NUM_ROWS],
  output logic [NUM_ROWS-1:0] sel_vec,
  output logic [NUM_ROWS-1:0] empty_vec,
  output logic                any_hit,
  output logic [IDX_W-1:0]    row_idx
);
  logic [NUM_ROWS-1:0] hit_vec;
  logic [CMP_W-1:0]    a_ext;

  assign a_ext = CMP_W'(addr);

  genvar g;
  generate
    for (g = 0; g < NUM_ROWS; g++) begin : g_cmp
      assign hit_vec[g]   = (CMP_W'(base[g]) <= a_ext) && (a_ext < CMP_W'(lim[g]));
      assign empty_vec[g] = (lim[g] == base[g]);
    end
  endgenerate

  // Isolate the lowest set bit, then encode it.
  assign sel_vec = hit_vec & (~hit_vec + NUM_ROWS'(1));
  assign any_hit = |hit_vec;

  always_comb begin
    row_idx = '0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (sel_vec[i]) row_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder
  import rbd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_row,
  input  logic [BND_W-1:0]  cfg_value,
  input  logic              look_valid,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit_valid,
  output logic              hit_in_range,
  output logic [IDX_W-1:0]  hit_row
);
  bnd_t                bnd  [NUM_ROWS];
  lim_t                lim  [NUM_ROWS];
  lim_t                base [NUM_ROWS];
  logic [NUM_ROWS-1:0] sel_vec;
  logic [NUM_ROWS-1:0] empty_vec;
  logic                any_hit;
  logic [IDX_W-1:0]    row_idx;

  rbd_regfile #(.NUM_ROWS(NUM_ROWS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_row),
    .wdata(cfg_value), .bnd(bnd)
  );

  rbd_limit_chain #(.NUM_ROWS(NUM_ROWS)) u_chain (
    .bnd(bnd), .lim(lim), .base(base)
  );

  rbd_match #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) u_match (
    .addr(look_addr), .lim(lim), .base(base), .sel_vec(sel_vec),
    .empty_vec(empty_vec), .any_hit(any_hit), .row_idx(row_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid    <= 1'b0;
      hit_in_range <= 1'b0;
      hit_row      <= '0;
    end else begin
      hit_valid <= look_valid;
      if (look_valid) begin
        hit_in_range <= any_hit;
        hit_row      <= any_hit ? row_idx : '0;
      end
    end
  end

  AST_ONE_ROW_PICKED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec)); // R6
  AST_EMPTY_NEVER_PICKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec & empty_vec) == '0); // R4
  AST_MISS_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_in_range) |-> (hit_row == '0)); // R7
  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |=> hit_valid); // R8
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !look_valid |=> (!hit_valid && $stable(hit_row) && $stable(hit_in_range))); // R8
endmodule

// File: tb/row_bound_decoder_test.sv
module row_bound_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_row = '0;
  logic [7:0]  cfg_value = '0;
  logic        look_valid = 1'b0;
  logic [31:0] look_addr = '0;
  logic        hit_valid;
  logic        hit_in_range;
  logic [2:0]  hit_row;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [31:0] addr;
    bit          inr;
    int          row;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   model [8];

  always #4 clk = ~clk;

  row_bound_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_value(cfg_value), .look_valid(look_valid), .look_addr(look_addr),
    .hit_valid(hit_valid), .hit_in_range(hit_in_range), .hit_row(hit_row)
  );

  // Reference: megabyte arithmetic, written from the requirements.
  function automatic void predict(input longint a, output bit inr, output int row);
    longint lo_mb, hi_mb, amb;
    inr = 0; row = 0; lo_mb = 0;
    amb = a / (1 << 20);
    for (int r = 0; r < 8; r++) begin
      if (model[r] == 0 && lo_mb != 0) hi_mb = 2048;
      else hi_mb = 8 * model[r];
      if (!inr && amb >= lo_mb && amb < hi_mb) begin
        inr = 1; row = r;
      end
      lo_mb = hi_mb;
    end
  endfunction

  task automatic wr(input int r, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 3'(r); cfg_value = 8'(v);
    model[r] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input string req);
    exp_t e;
    bit inr; int row;
    @(negedge clk);
    predict(longint'(a), inr, row);
    e.addr = a; e.inr = inr; e.row = row; e.req = req;
    exp_q.push_back(e);
    look_valid = 1'b1; look_addr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      look_valid = 1'b0;
    end
  endtask

  // Monitor: compares every result strobe against the queue.
  always @(negedge clk) begin
    if (rst_n && hit_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R8: result strobe with nothing pending (actual 1, expected 0)");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (hit_in_range !== e.inr || int'(hit_row) != e.row) begin
          n_fails++;
          $display("FAIL %s: addr %h actual inr=%0d row=%0d expected inr=%0d row=%0d",
                   e.req, e.addr, hit_in_range, hit_row, e.inr, e.row);
        end
      end
    end
  end

  initial begin : watchdog
    #1600000;
    n_fails++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (hit_valid !== 1'b0 || hit_in_range !== 1'b0 || hit_row !== 3'd0) begin
      n_fails++;
      $display("FAIL R1: reset outputs actual %b%b%0d expected 000", hit_valid, hit_in_range, hit_row);
    end
    // R1: nothing is in range before programming
    look(32'h0000_0000, "R1");
    look(32'h7FFF_FFFF, "R1");
    look(32'hFFFF_FFFF, "R1");
    idle(2);
    // R8: no strobe while idle
    n_checks++;
    if (hit_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R8: strobe while idle actual %b expected 0", hit_valid);
    end

    // R2/R3/R4: monotonic layout with an empty row 1
    wr(0, 2); wr(1, 2);
    for (int r = 2; r < 8; r++) wr(r, 6);
    look(32'h0000_0000, "R3");
    look(32'h00FF_FFFF, "R3");
    look(32'h0100_0000, "R4");
    look(32'h02FF_FFFF, "R3");
    look(32'h0300_0000, "R7");
    look(32'hFFFF_FFFF, "R7");
    idle(2);

    // R2: a single rewrite moves the top boundary
    wr(2, 8);
    look(32'h0300_0000, "R2");
    look(32'h0400_0000, "R7");
    idle(2);

    // R5: top row reaches 2 GB through a zero
    wr(2, 6);
    wr(3, 255); wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0);
    look(32'h7F7F_FFFF, "R3");
    look(32'h7F80_0000, "R5");
    look(32'h7FFF_FFFF, "R5");
    look(32'h8000_0000, "R5");
    idle(2);

    // R6: overlapping ranges from a non-monotonic layout
    wr(0, 4); wr(1, 8); wr(2, 2); wr(3, 6);
    wr(4, 10); wr(5, 10); wr(6, 10); wr(7, 10);
    look(32'h0140_0000, "R6");
    look(32'h0280_0000, "R6");
    look(32'h0400_0000, "R6");
    look(32'h04FF_FFFF, "R6");
    look(32'h0500_0000, "R7");
    idle(3);

    // R1: a second reset clears all boundaries
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    look(32'h0000_1000, "R1");
    idle(3);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R8: %0d results missing (expected 0)", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule